// File: doc/BRIEF.md
# Private address resolution sequencer

This block takes a received 48-bit private device address and tests it against a list of 128-bit identity keys. It reads a byte stream that holds a 24-bit hash and a 24-bit random part, followed by the keys, 16 bytes each. For every key it builds a 128-bit plaintext from the random part and hands key and plaintext to an external AES-128 engine through a request/acknowledge handshake. It then compares the low 24 bits of the engine's result with the hash. Each matching key's zero-based index goes out on a byte stream, and the block keeps a running output amount.

Software-style task pulses start and abort a run. Single-cycle event pulses report the outcome: resolved, not resolved, end and error. A run lasts a modelled number of cycles that grows with the keys checked and the matches found. The walk stops early at a programmable match limit or at a fixed key limit.

Top module: `arp_resolver`

## Requirements
- R1: Input bytes 0..2 form the hash and bytes 3..5 form the random part, each least significant byte first. The AES plaintext is zero except bits [23:0], which hold the random part, so byte 13 carries its top byte. Resolution proceeds whatever the top two bits of the random part are.
- R2: Key bytes are packed in arrival order, with the first key byte in bits [127:120] of the key sent to the engine.
- R3: A key matches when bits [23:0] of the engine result equal the hash. For each match, the 16-bit key index goes out low byte first, and the output amount becomes twice the match count.
- R4: Before each key, the walk continues only while the match count is below the limit sampled at START and fewer than MAX_KEYS keys have been checked. A limit of 0 checks no key.
- R5: A last flag on the 16th byte of a key ends the list once that key has been checked. A last flag on the 6th header byte gives an empty list. Both end normally.
- R6: A last flag on any other header byte, or on key bytes 1 to 15, sets error status 1, pulses ERROR and returns the block to idle.
- R7: If out_full_i is high while an index byte is pending, the block sets error status 2, pulses ERROR and returns to idle.
- R8: On normal completion, RESOLVED pulses if the output amount is nonzero and NOTRESOLVED pulses otherwise. END pulses the next cycle, and busy falls with END.
- R9: If input, engine and output keep up, the outcome pulse is high in the cycle that begins 20 + 28·keys + 11·matches clock edges after the edge that samples START.
- R10: START while busy has no effect on the run or its results.
- R11: STOP while busy pulses ERROR the next cycle and returns to idle, leaving the error status unchanged. STOP while idle does nothing.
- R12: An accepted START clears the error status and the output amount to 0.
- R13: The engine request stays high with a stable key and plaintext until it is acknowledged. A pending output byte stays valid and stable until it is accepted or the output reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start task pulse |
| stop_i | input | 1 | Stop task pulse |
| max_res_i | input | MAXRES_W | Match limit, sampled at START |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte is the last of the list |
| in_ready_o | output | 1 | Block accepts an input byte |
| aes_req_o | output | 1 | Engine request |
| aes_key_o | output | 128 | Engine key |
| aes_blk_o | output | 128 | Engine plaintext |
| aes_ack_i | input | 1 | Engine acknowledge, result valid |
| aes_res_i | input | 128 | Engine result |
| out_valid_o | output | 1 | Output index byte valid |
| out_data_o | output | 8 | Output index byte |
| out_ready_i | input | 1 | Output sink accepts a byte |
| out_full_i | input | 1 | Output sink has no room left |
| busy_o | output | 1 | A run is in progress |
| err_status_o | output | 2 | 0 none, 1 input ended early, 2 output ran out |
| out_amount_o | output | AMT_W | Twice the number of matches |
| ev_resolved_o | output | 1 | Resolved event pulse |
| ev_notresolved_o | output | 1 | Not-resolved event pulse |
| ev_end_o | output | 1 | End event pulse |
| ev_error_o | output | 1 | Error event pulse |

## Verification
Random runs mix key lists of 0 to 8 keys with match limits of 0 to 5 and scattered matching keys, against a small key limit. This tells apart runs that end on the list end, on the match limit and on the key limit, and the exact outcome cycle pins down the number of keys checked. Because the engine model folds the plaintext into the result, a wrong byte order in key, plaintext or hash makes every expected match disappear. Directed runs place the last flag inside the header and inside a key, starve the output after one byte, and pulse STOP or a second START in mid-run to separate the abort, error and ignore paths.

// File: rtl/arp_pkg.sv
// Shared constants and state type of the address resolution sequencer.
package arp_pkg;
    localparam int HDR_BYTES = 6;
    localparam int KEY_BYTES = 16;
    localparam int COST_BASE = 20;
    localparam int COST_KEY  = 28;
    localparam int COST_HIT  = 11;

    localparam logic [1:0] ERR_NONE     = 2'd0;
    localparam logic [1:0] ERR_IN_SHORT = 2'd1;
    localparam logic [1:0] ERR_OUT_FULL = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_KEY, ST_AES, ST_WR0, ST_WR1, ST_WAIT, ST_FIN
    } arp_state_t;
endpackage

// File: rtl/arp_byte_gather.sv
// Byte collector: shifts accepted bytes in at the bottom, so the first byte
// of a group ends up most significant. Assumes clr and take never need the
// data kept across a clear.
module arp_byte_gather #(
    parameter int NBYTES = 16,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  take_i,
    input  logic [7:0]            byte_i,
    output logic [NBYTES*8-1:0]   data_o,
    output logic [NBYTES*8-1:0]   nxt_o,
    output logic [CNT_W-1:0]      cnt_o
);
    assign nxt_o = {data_o[NBYTES*8-9:0], byte_i};

    // shift register and byte position within the current group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else begin
            if (take_i) data_o <= nxt_o;
            if (clr_i)       cnt_o <= '0;
            else if (take_i) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/arp_cost_timer.sv
// Run-length model: counts cycles since START and flags when the next edge
// reaches base + per-key * keys + per-match * matches. Assumes keys/hits
// are final while the owner waits on due_o.
module arp_cost_timer #(
    parameter int CNT_W  = 13,
    parameter int TIME_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  keys_i,
    input  logic [CNT_W-1:0]  hits_i,
    output logic              due_o
);
    import arp_pkg::*;
    logic [TIME_W-1:0] elapsed;
    logic [TIME_W-1:0] target;

    assign target = TIME_W'(COST_BASE) + TIME_W'(COST_KEY) * TIME_W'(keys_i)
                  + TIME_W'(COST_HIT) * TIME_W'(hits_i);
    assign due_o  = (elapsed + 1'b1) >= target;

    // saturating cycle count since the accepted START
    always_ff @(posedge clk) begin
        if (!rst_n)                      elapsed <= '0;
        else if (clr_i)                  elapsed <= '0;
        else if (run_i && elapsed != '1) elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/arp_resolver.sv
// Address resolution sequencer top: parses the header, walks keys one at a
// time through an external AES engine, emits matching key indices and the
// outcome events. Assumes the engine tolerates a dropped request on STOP.
module arp_resolver #(
    parameter int MAX_KEYS = 4096,
    parameter int MAXRES_W = 16,
    localparam int IDX_W  = $clog2(MAX_KEYS + 1),
    localparam int AMT_W  = IDX_W + 1,
    localparam int TIME_W = $clog2(20 + 39 * MAX_KEYS + 1) + 1,
    localparam int CMP_W  = (IDX_W > MAXRES_W) ? IDX_W : MAXRES_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [MAXRES_W-1:0] max_res_i,
    input  logic                in_valid_i,
    input  logic [7:0]          in_data_i,
    input  logic                in_last_i,
    output logic                in_ready_o,
    output logic                aes_req_o,
    output logic [127:0]        aes_key_o,
    output logic [127:0]        aes_blk_o,
    input  logic                aes_ack_i,
    input  logic [127:0]        aes_res_i,
    output logic                out_valid_o,
    output logic [7:0]          out_data_o,
    input  logic                out_ready_i,
    input  logic                out_full_i,
    output logic                busy_o,
    output logic [1:0]          err_status_o,
    output logic [AMT_W-1:0]    out_amount_o,
    output logic                ev_resolved_o,
    output logic                ev_notresolved_o,
    output logic                ev_end_o,
    output logic                ev_error_o
);
    import arp_pkg::*;
    localparam int G_CNT_W = $clog2(KEY_BYTES);

    arp_state_t          state;
    logic [23:0]         hash_q, prand_q;
    logic [IDX_W-1:0]    idx_q, cnt_q, idx_inc;
    logic [MAXRES_W-1:0] max_q;
    logic                lend_q, take, g_clr, go_on, due;
    logic [127:0]        g_data, g_nxt;
    logic [G_CNT_W-1:0]  g_cnt;
    logic [15:0]         idx16;

    assign busy_o      = (state != ST_IDLE);
    assign in_ready_o  = (state == ST_HDR) || (state == ST_KEY);
    assign take        = in_valid_i && in_ready_o;
    assign aes_req_o   = (state == ST_AES);
    assign aes_key_o   = g_data;
    assign aes_blk_o   = {104'd0, prand_q};
    assign out_valid_o = (state == ST_WR0) || (state == ST_WR1);
    assign idx16       = 16'(idx_q);
    assign out_data_o  = (state == ST_WR1) ? idx16[15:8] : idx16[7:0];
    assign idx_inc     = idx_q + 1'b1;
    assign go_on       = !lend_q && (CMP_W'(cnt_q) < CMP_W'(max_q))
                         && (idx_inc < IDX_W'(MAX_KEYS));
    assign g_clr       = ((state == ST_IDLE) && start_i)
                         || ((state == ST_HDR) && take && g_cnt == G_CNT_W'(HDR_BYTES - 1));

    arp_byte_gather #(.NBYTES(KEY_BYTES)) u_gather (
        .clk(clk), .rst_n(rst_n), .clr_i(g_clr), .take_i(take),
        .byte_i(in_data_i), .data_o(g_data), .nxt_o(g_nxt), .cnt_o(g_cnt)
    );

    arp_cost_timer #(.CNT_W(IDX_W), .TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(g_clr && state == ST_IDLE),
        .run_i(busy_o), .keys_i(idx_q), .hits_i(cnt_q), .due_o(due)
    );

    // sequencer: tasks, header/key parsing, compare, index writes, events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hash_q <= '0; prand_q <= '0; idx_q <= '0; cnt_q <= '0;
            max_q <= '0; lend_q <= 1'b0;
            err_status_o <= ERR_NONE; out_amount_o <= '0;
            ev_resolved_o <= 1'b0; ev_notresolved_o <= 1'b0;
            ev_end_o <= 1'b0; ev_error_o <= 1'b0;
        end else begin
            ev_resolved_o <= 1'b0; ev_notresolved_o <= 1'b0;
            ev_end_o <= 1'b0; ev_error_o <= 1'b0;
            if (busy_o && stop_i) begin
                state <= ST_IDLE;
                ev_error_o <= 1'b1;
            end else begin
                case (state)
                    ST_IDLE: if (start_i) begin
                        state <= ST_HDR;
                        err_status_o <= ERR_NONE; out_amount_o <= '0;
                        idx_q <= '0; cnt_q <= '0; lend_q <= 1'b0;
                        max_q <= max_res_i;
                    end
                    ST_HDR: if (take) begin
                        if (g_cnt == G_CNT_W'(HDR_BYTES - 1)) begin
                            hash_q  <= {g_nxt[31:24], g_nxt[39:32], g_nxt[47:40]};
                            prand_q <= {g_nxt[7:0], g_nxt[15:8], g_nxt[23:16]};
                            state   <= (in_last_i || max_q == '0) ? ST_WAIT : ST_KEY;
                        end else if (in_last_i) begin
                            err_status_o <= ERR_IN_SHORT; ev_error_o <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    ST_KEY: if (take) begin
                        if (g_cnt == G_CNT_W'(KEY_BYTES - 1)) begin
                            lend_q <= in_last_i;
                            state  <= ST_AES;
                        end else if (in_last_i) begin
                            err_status_o <= ERR_IN_SHORT; ev_error_o <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    ST_AES: if (aes_ack_i) begin
                        if (aes_res_i[23:0] == hash_q) begin
                            cnt_q <= cnt_q + 1'b1;
                            out_amount_o <= AMT_W'(cnt_q + 1'b1) << 1;
                            state <= ST_WR0;
                        end else begin
                            idx_q <= idx_inc;
                            state <= go_on ? ST_KEY : ST_WAIT;
                        end
                    end
                    ST_WR0, ST_WR1: begin
                        if (out_full_i) begin
                            err_status_o <= ERR_OUT_FULL; ev_error_o <= 1'b1;
                            state <= ST_IDLE;
                        end else if (out_ready_i) begin
                            if (state == ST_WR0) state <= ST_WR1;
                            else begin
                                idx_q <= idx_inc;
                                state <= go_on ? ST_KEY : ST_WAIT;
                            end
                        end
                    end
                    ST_WAIT: if (due) begin
                        ev_resolved_o    <= (out_amount_o != '0);
                        ev_notresolved_o <= (out_amount_o == '0);
                        state <= ST_FIN;
                    end
                    ST_FIN: begin
                        ev_end_o <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/arp_resolver_chk.sv
// Protocol and task-rule checks for arp_resolver, attached through bind.
module arp_resolver_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         stop_i,
    input logic         in_ready_o,
    input logic         aes_req_o,
    input logic [127:0] aes_key_o,
    input logic [127:0] aes_blk_o,
    input logic         aes_ack_i,
    input logic         out_valid_o,
    input logic [7:0]   out_data_o,
    input logic         out_ready_i,
    input logic         out_full_i,
    input logic         busy_o,
    input logic [1:0]   err_status_o,
    input logic         ev_resolved_o,
    input logic         ev_notresolved_o,
    input logic         ev_end_o,
    input logic         ev_error_o
);
    // R8
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_resolved_o, ev_notresolved_o, ev_end_o, ev_error_o}));
    // R8
    end_after_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end_o |-> $past(ev_resolved_o || ev_notresolved_o) && !busy_o);
    // R11
    stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && stop_i |=> ev_error_o && !busy_o);
    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && stop_i && !start_i |=> !ev_error_o && !busy_o);
    // R12
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && err_status_o == 2'd0);
    // R13
    aes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aes_req_o && !aes_ack_i && !stop_i |=> aes_req_o && $stable(aes_key_o) && $stable(aes_blk_o));
    // R13
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i && !out_full_i && !stop_i |=> out_valid_o && $stable(out_data_o));
    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o);
endmodule

bind arp_resolver arp_resolver_chk u_chk (.*);

// File: tb/arp_resolver_test.sv
module arp_resolver_test;
    localparam int MAXK = 6;
    localparam int AW = $clog2(MAXK + 1) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0;
    logic [7:0] max_res = '0;
    logic in_valid, in_last, in_ready_o;
    logic [7:0] in_data;
    logic aes_req_o, aes_ack = 1'b0;
    logic [127:0] aes_key_o, aes_blk_o, aes_res;
    logic out_valid_o, out_ready, out_full;
    logic [7:0] out_data_o;
    logic busy_o;
    logic [1:0] err_status_o;
    logic [AW-1:0] out_amount_o;
    logic ev_res, ev_nres, ev_end, ev_err;

    always #4 clk = ~clk;

    arp_resolver #(.MAX_KEYS(MAXK), .MAXRES_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .max_res_i(max_res), .in_valid_i(in_valid), .in_data_i(in_data),
        .in_last_i(in_last), .in_ready_o(in_ready_o), .aes_req_o(aes_req_o),
        .aes_key_o(aes_key_o), .aes_blk_o(aes_blk_o), .aes_ack_i(aes_ack),
        .aes_res_i(aes_res), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready), .out_full_i(out_full), .busy_o(busy_o),
        .err_status_o(err_status_o), .out_amount_o(out_amount_o),
        .ev_resolved_o(ev_res), .ev_notresolved_o(ev_nres),
        .ev_end_o(ev_end), .ev_error_o(ev_err)
    );

    logic [7:0] stim [0:255];
    int slen = 0, last_at = -1, ptr = 0, ocnt = 0, room_q = 64, cyc = 0;
    int n_res = 0, n_nres = 0, n_end = 0, n_err = 0, t_out = 0, t_end = 0, s_cyc = 0;
    logic [7:0] obuf [0:31];
    logic tb_clr = 1'b0;
    int tests = 0, fails = 0;
    logic [23:0] hsh, prn;
    bit mt [0:15];
    int nk;

    assign in_valid  = (ptr < slen);
    assign in_data   = stim[ptr[7:0]];
    assign in_last   = (ptr == last_at);
    assign out_full  = (ocnt >= room_q);
    assign out_ready = !out_full;
    // engine model: low bits fold key top bytes with the plaintext low bits
    assign aes_res = {~aes_key_o[103:0],
                      aes_key_o[127:104] ^ aes_blk_o[23:0] ^ ((|aes_blk_o[127:24]) ? 24'h5A5A5A : 24'h0)};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        aes_ack <= aes_req_o && !aes_ack;
        if (tb_clr) begin
            ptr <= 0; ocnt <= 0; n_res <= 0; n_nres <= 0; n_end <= 0; n_err <= 0;
            t_out <= 0; t_end <= 0;
        end else begin
            if (in_valid && in_ready_o) ptr <= ptr + 1;
            if (out_valid_o && out_ready && !out_full) begin
                obuf[ocnt[4:0]] <= out_data_o; ocnt <= ocnt + 1;
            end
            if (ev_res)  begin n_res <= n_res + 1; t_out <= cyc; end
            if (ev_nres) begin n_nres <= n_nres + 1; t_out <= cyc; end
            if (ev_end)  begin n_end <= n_end + 1; t_end <= cyc; end
            if (ev_err)  n_err <= n_err + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(input int nkeys, input bit top11);
        int p = 0;
        hsh = 24'($urandom); prn = 24'($urandom);
        if (top11) prn[23:22] = 2'b11;
        nk = nkeys;
        stim[0] = hsh[7:0]; stim[1] = hsh[15:8]; stim[2] = hsh[23:16];
        stim[3] = prn[7:0]; stim[4] = prn[15:8]; stim[5] = prn[23:16];
        p = 6;
        for (int k = 0; k < nkeys; k++) begin
            logic [23:0] top = hsh ^ prn;
            if (!mt[k]) top = top ^ 24'($urandom_range(1, 24'hFFFFFF));
            stim[p] = top[23:16]; stim[p+1] = top[15:8]; stim[p+2] = top[7:0];
            for (int b = 3; b < 16; b++) stim[p+b] = 8'($urandom);
            p += 16;
        end
        slen = p; last_at = p - 1;
    endtask

    task automatic launch(input int maxr, input int room);
        @(negedge clk); tb_clr = 1'b1; max_res = 8'(maxr); room_q = room;
        @(negedge clk); tb_clr = 1'b0; start_i = 1'b1;
        @(posedge clk); s_cyc = cyc;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic finish_run();
        while (busy_o) @(negedge clk);
        @(negedge clk); @(negedge clk);
    endtask

    // compare a normally completed run against the bench model
    task automatic check_normal(input int maxr, input string tag);
        int idx = 0, cnt = 0, cexp;
        int exp_idx [0:15];
        bit bytes_ok = 1'b1;
        while (cnt < maxr && idx < MAXK && idx < nk) begin
            if (mt[idx]) begin exp_idx[cnt] = idx; cnt++; end
            idx++;
        end
        cexp = 20 + 28 * idx + 11 * cnt;
        chk(cnt > 0 ? (n_res == 1 && n_nres == 0) : (n_nres == 1 && n_res == 0),
            "R8", {tag, " outcome"}, n_res, cnt > 0 ? 1 : 0);
        chk(t_out - s_cyc == cexp + 1, "R9", {tag, " outcome cycle"}, t_out - s_cyc, cexp + 1);
        chk(n_end == 1 && t_end == t_out + 1, "R8", {tag, " end follows"}, t_end - t_out, 1);
        chk(int'(out_amount_o) == 2 * cnt, "R3", {tag, " amount"}, int'(out_amount_o), 2 * cnt);
        for (int i = 0; i < cnt; i++)
            if (obuf[2*i] != 8'(exp_idx[i]) || obuf[2*i+1] != 8'h00) bytes_ok = 1'b0;
        chk(ocnt == 2 * cnt && bytes_ok, "R4", {tag, " index bytes"}, ocnt, 2 * cnt);
        chk(err_status_o == 2'd0 && n_err == 0, "R6", {tag, " no error"}, int'(err_status_o), 0);
    endtask

    initial begin
        int unsigned seed = 32'd4242;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !in_ready_o && !aes_req_o && !out_valid_o && err_status_o == 0
            && out_amount_o == 0 && !ev_res && !ev_nres && !ev_end && !ev_err,
            "R12", "reset state", int'(busy_o), 0);

        // R1 directed: non-resolvable top bits, single matching key
        mt[0] = 1'b1; build(1, 1'b1); launch(3, 64); finish_run(); check_normal(3, "R1 top11");
        // R2 R5 directed: empty key list, last on header byte 6
        build(0, 1'b0); launch(3, 64); finish_run(); check_normal(3, "R5 empty");
        // R4 directed: limit 0 checks no key
        for (int k = 0; k < 4; k++) mt[k] = 1'b1;
        build(4, 1'b0); launch(0, 64); finish_run(); check_normal(0, "R4 limit0");
        // R4 directed: hard key limit with all keys matching
        for (int k = 0; k < 8; k++) mt[k] = 1'b1;
        build(8, 1'b0); launch(15, 64); finish_run(); check_normal(15, "R4 keylimit");

        // R2 R3 R5 random runs
        for (int r = 0; r < 30; r++) begin
            int nkr = $urandom_range(0, 8);
            int mr  = $urandom_range(0, 5);
            for (int k = 0; k < 16; k++) mt[k] = ($urandom_range(0, 1) == 1);
            build(nkr, 1'b0); launch(mr, 64); finish_run(); check_normal(mr, "R2 R3 random");
        end

        // R10: second START in mid-run changes nothing
        for (int k = 0; k < 4; k++) mt[k] = (k != 1);
        build(4, 1'b0); launch(5, 64);
        repeat (20) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        finish_run(); check_normal(5, "R10 restart");

        // R6: last flag on header byte 3
        build(2, 1'b0); last_at = 2; launch(3, 64); finish_run();
        chk(err_status_o == 2'd1 && n_err == 1 && n_res + n_nres + n_end == 0,
            "R6", "short header", int'(err_status_o), 1);
        // R6: last flag on byte 8 of the second key
        build(2, 1'b0); last_at = 6 + 16 + 7; launch(3, 64); finish_run();
        chk(err_status_o == 2'd1 && n_err == 1 && n_end == 0, "R6", "short key", int'(err_status_o), 1);
        // R12: START clears the error status
        mt[0] = 1'b0; build(1, 1'b0); launch(3, 64); finish_run(); check_normal(3, "R12 clear");

        // R7: room for one byte only, first key matches
        mt[0] = 1'b1; build(2, 1'b0); launch(3, 1); finish_run();
        chk(err_status_o == 2'd2 && n_err == 1 && n_end == 0, "R7", "output full status", int'(err_status_o), 2);
        chk(int'(out_amount_o) == 2 && ocnt == 1, "R7", "amount at full", int'(out_amount_o), 2);

        // R11: STOP mid-run after an error left status 2
        build(3, 1'b0); launch(3, 64);
        repeat (12) @(negedge clk);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(n_err == 1 && !busy_o && n_res + n_nres + n_end == 0, "R11", "stop while busy", n_err, 1);
        chk(err_status_o == 2'd0, "R11", "stop keeps status", int'(err_status_o), 0);
        // R11: STOP while idle
        @(negedge clk); tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(n_err == 0 && !busy_o, "R11", "stop while idle", n_err, 0);
        // R13: a run after the abort still completes (request/valid hold under the checker)
        mt[0] = 1'b1; mt[1] = 1'b1; build(2, 1'b0); launch(2, 64); finish_run(); check_normal(2, "R13 after stop");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule